// File: doc/BRIEF.md
# Programmable Watchdog Timer with Output Steering

This block watches a processor for signs of life. Software writes one 8-bit control word that sets the timeout. The timeout is a 5-bit multiplier times one of four step sizes, all counted from a single-cycle 16 Hz `tick`. A one-bit steering field selects the response to a missed deadline. In one setting the block raises a level on the shared interrupt/test pin and holds it. In the other it drives an active-low reset pulse two ticks long (125 ms), then clears the control word and asks the neighbouring logic to clear its frequency-test bit. Either response also sets a watchdog flag, which stays set until the flags register is read.

Software keeps the watchdog quiet in one of two ways: it writes the control word again, or it toggles the `kick` pin in either direction. The kick pin passes through a two-flop synchronizer before its edge detector. A power-fail indication clears the control word and returns the block to its idle state. The block has four states. `WD_IDLE` means no countdown is running. `WD_ARMED` means the countdown is running. `WD_IRQ_HOLD` means the interrupt is held. `WD_RST_PULSE` means the reset pulse is being driven. The transitions are:
- arm: `WD_IDLE` to `WD_ARMED`, when the stored multiplier is non-zero.
- disarm: `WD_ARMED` to `WD_IDLE`, on a write with multiplier 0.
- expire-irq: `WD_ARMED` to `WD_IRQ_HOLD`.
- expire-rst: `WD_ARMED` to `WD_RST_PULSE`.
- release: `WD_IRQ_HOLD` to `WD_IDLE`, on a write of 00h.
- pulse-done: `WD_RST_PULSE` to `WD_IDLE`.
- power-off: any state to `WD_IDLE`, on `pwr_fail`.

Top module: `wdog_steer_top`

## Requirements
- R1: A write stores `wr_data` as the control word: bit 7 is steering, bits 6..2 are the multiplier, bits 1..0 are the step code. `rd_data` returns the stored word on the cycle after the write.
- R2: The step code sets the ticks per multiplier unit: 00 gives 1 tick, 01 gives 4, 10 gives 16 and 11 gives 64. The timeout fires on exactly the multiplier × step-th tick after the countdown restarts. For example, 8'b00001110 times out on tick 48.
- R3: With steering 0, a timeout drives `irq_ft` high and sets `wdf`. Both appear one cycle after the expiring tick, and `irq_ft` stays high.
- R4: With steering 1, a timeout does the following one cycle after the expiring tick. It drives `rst_out_n` low, clears the control word so `rd_data` reads 00h, pulses `ft_clr` for one cycle, and sets `wdf`. `rst_out_n` returns high one cycle after the second following tick.
- R5: `flag_rd` clears `wdf`. If a timeout happens in the same cycle as `flag_rd`, the flag stays set.
- R6: Any control-word write while armed restarts the countdown from its full length.
- R7: A rising or a falling edge on `kick` restarts the countdown. The restart happens three clock cycles after the edge.
- R8: A write with multiplier 0 stops the countdown, so no timeout follows. While the interrupt is held, only a write of exactly 00h releases `irq_ft`; any other write leaves it high.
- R9: `pwr_fail` clears the control word, releases `irq_ft` and `rst_out_n`, and returns the block to idle. No timeout follows until the block is armed again.
- R10: When the watchdog is not holding the interrupt, `irq_ft` carries `ft_en & ft_wave`. A held watchdog interrupt forces `irq_ft` high whatever `ft_wave` is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Single-cycle 16 Hz timebase strobe |
| wr_en | input | 1 | Control-word write strobe |
| wr_data | input | 8 | Control word to write |
| rd_data | output | 8 | Stored control word |
| flag_rd | input | 1 | Flags-register read strobe; clears `wdf` |
| kick | input | 1 | Service pin; either edge restarts the count |
| pwr_fail | input | 1 | Power-down indication |
| ft_en | input | 1 | Frequency-test output enabled |
| ft_wave | input | 1 | Frequency-test square wave |
| irq_ft | output | 1 | Shared interrupt / frequency-test output |
| rst_out_n | output | 1 | Active-low watchdog reset pulse |
| wdf | output | 1 | Watchdog flag |
| ft_clr | output | 1 | One-cycle request to clear the frequency-test bit |

## Verification
Most results come from the state register, so they appear one clock after the edge that causes them. The bench therefore drives each stimulus for one cycle starting at a falling edge, and samples at the next falling edge.

That covers several results:
- A timeout is due one cycle after its tick.
- A register write shows on `rd_data` one cycle after the write.
- `wdf` clears one cycle after `flag_rd`.
- The end of the reset pulse shows one cycle after the second tick of the pulse.

A kick edge crosses two synchronizer flops and the edge detector, so it restarts the count three cycles later. The bench waits five idle cycles before the next tick, so no tick can land before the restart. `irq_ft` follows `ft_wave` combinationally, and the bench samples it in the same half cycle it drives `ft_wave`.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    localparam int CTRL_W        = 8;
    localparam int MULT_W        = 5;
    localparam int CODE_W        = 2;
    localparam int STEP_LOG2     = 2;
    localparam int NUM_CODES     = 1 << CODE_W;
    localparam int SUB_W         = STEP_LOG2 * (NUM_CODES - 1);
    localparam int PULSE_TICKS   = 2;
    localparam int SYNC_STAGES   = 2;

    typedef enum logic [1:0] {
        WD_IDLE      = 2'd0,
        WD_ARMED     = 2'd1,
        WD_IRQ_HOLD  = 2'd2,
        WD_RST_PULSE = 2'd3
    } wd_state_e;

    typedef struct packed {
        logic              steer;
        logic [MULT_W-1:0] mult;
        logic [CODE_W-1:0] code;
    } wd_ctrl_t;
endpackage

// File: rtl/wdog_kick_sync.sv
module wdog_kick_sync #(
    parameter int STAGES = wdog_pkg::SYNC_STAGES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kick,
    output logic kick_edge
);
    logic [STAGES:0] sync_q;

    generate
        for (genvar i = 0; i <= STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[0] <= 1'b0;
                    else        sync_q[0] <= kick;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[i] <= 1'b0;
                    else        sync_q[i] <= sync_q[i-1];
                end
            end
        end
    endgenerate

    assign kick_edge = sync_q[STAGES] ^ sync_q[STAGES-1];
endmodule

// File: rtl/wdog_countdown.sv
module wdog_countdown
    import wdog_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              restart,
    input  logic              tick,
    input  logic [MULT_W-1:0] load_mult,
    input  logic [CODE_W-1:0] load_code,
    output logic              expire
);
    logic [SUB_W-1:0]  sub_q;
    logic [MULT_W-1:0] left_q;
    logic [CODE_W-1:0] code_q;
    logic [SUB_W-1:0]  sub_last;
    logic              step_done;

    always_comb begin
        sub_last = '0;
        for (int c = 0; c < NUM_CODES; c++) begin
            if (code_q == CODE_W'(c))
                sub_last = SUB_W'((64'd1 << (STEP_LOG2 * c)) - 64'd1);
        end
    end

    assign step_done = run && tick && (sub_q == sub_last);
    assign expire    = step_done && !restart && (left_q == MULT_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sub_q  <= '0;
            left_q <= '0;
            code_q <= '0;
        end else if (restart) begin
            sub_q  <= '0;
            left_q <= load_mult;
            code_q <= load_code;
        end else if (run && tick) begin
            if (sub_q == sub_last) begin
                sub_q <= '0;
                if (left_q != '0) left_q <= left_q - MULT_W'(1);
            end else begin
                sub_q <= sub_q + SUB_W'(1);
            end
        end
    end
endmodule

// File: rtl/wdog_fsm.sv
module wdog_fsm
    import wdog_pkg::*;
#(
    parameter int PULSE_LEN = PULSE_TICKS
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  logic      expire,
    input  logic      steer,
    input  logic      ctrl_on,
    input  logic      wr_en,
    input  logic      wr_zero,
    input  logic      wr_mult_zero,
    input  logic      pwr_fail,
    input  logic      flag_rd,
    output wd_state_e state,
    output logic      clear_ctrl,
    output logic      irq_wd,
    output logic      rst_drv_n,
    output logic      wdf,
    output logic      ft_clr
);
    localparam int PCW = $clog2(PULSE_LEN + 1);

    wd_state_e      state_q, state_d;
    logic [PCW-1:0] pulse_q;
    logic           fire;
    logic           pulse_end;

    assign fire      = (state_q == WD_ARMED) && expire && !pwr_fail;
    assign pulse_end = tick && (pulse_q == PCW'(PULSE_LEN - 1));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WD_IDLE: begin
                if (!pwr_fail && ctrl_on) state_d = WD_ARMED;
            end
            WD_ARMED: begin
                if (pwr_fail)                   state_d = WD_IDLE;
                else if (wr_en && wr_mult_zero) state_d = WD_IDLE;
                else if (expire)                state_d = steer ? WD_RST_PULSE : WD_IRQ_HOLD;
            end
            WD_IRQ_HOLD: begin
                if (pwr_fail || (wr_en && wr_zero)) state_d = WD_IDLE;
            end
            WD_RST_PULSE: begin
                if (pwr_fail || pulse_end) state_d = WD_IDLE;
            end
            default: state_d = WD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WD_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pulse_q <= '0;
            wdf     <= 1'b0;
            ft_clr  <= 1'b0;
        end else begin
            if (state_q != WD_RST_PULSE) pulse_q <= '0;
            else if (tick)               pulse_q <= pulse_q + PCW'(1);
            if (fire)         wdf <= 1'b1;
            else if (flag_rd) wdf <= 1'b0;
            ft_clr <= fire && steer;
        end
    end

    always_comb begin
        state      = state_q;
        irq_wd     = (state_q == WD_IRQ_HOLD);
        rst_drv_n  = (state_q != WD_RST_PULSE);
        clear_ctrl = fire && steer;
    end
endmodule

// File: rtl/wdog_steer_top.sv
module wdog_steer_top
    import wdog_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    input  logic       flag_rd,
    input  logic       kick,
    input  logic       pwr_fail,
    input  logic       ft_en,
    input  logic       ft_wave,
    output logic       irq_ft,
    output logic       rst_out_n,
    output logic       wdf,
    output logic       ft_clr
);
    wd_ctrl_t  ctrl_q;
    wd_ctrl_t  wr_ctrl;
    wd_ctrl_t  load_ctrl;
    wd_state_e wd_state;
    logic      kick_edge;
    logic      expire;
    logic      restart;
    logic      clear_ctrl;
    logic      irq_wd;

    assign wr_ctrl   = wd_ctrl_t'(wr_data);
    assign load_ctrl = wr_en ? wr_ctrl : ctrl_q;
    assign restart   = wr_en || kick_edge || (wd_state != WD_ARMED);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          ctrl_q <= '0;
        else if (pwr_fail)   ctrl_q <= '0;
        else if (clear_ctrl) ctrl_q <= '0;
        else if (wr_en)      ctrl_q <= wr_ctrl;
    end

    wdog_kick_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .kick      (kick),
        .kick_edge (kick_edge)
    );

    wdog_countdown u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (wd_state == WD_ARMED),
        .restart   (restart),
        .tick      (tick),
        .load_mult (load_ctrl.mult),
        .load_code (load_ctrl.code),
        .expire    (expire)
    );

    wdog_fsm #(.PULSE_LEN(PULSE_TICKS)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (tick),
        .expire       (expire),
        .steer        (ctrl_q.steer),
        .ctrl_on      (ctrl_q.mult != '0),
        .wr_en        (wr_en),
        .wr_zero      (wr_data == 8'h00),
        .wr_mult_zero (wr_ctrl.mult == '0),
        .pwr_fail     (pwr_fail),
        .flag_rd      (flag_rd),
        .state        (wd_state),
        .clear_ctrl   (clear_ctrl),
        .irq_wd       (irq_wd),
        .rst_drv_n    (rst_out_n),
        .wdf          (wdf),
        .ft_clr       (ft_clr)
    );

    assign rd_data = ctrl_q;
    assign irq_ft  = irq_wd || (ft_en && ft_wave);
endmodule

// File: rtl/wdog_steer_chk.sv
module wdog_steer_chk
    import wdog_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       tick,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic       flag_rd,
    input logic       pwr_fail,
    input logic       irq_ft,
    input logic       rst_out_n,
    input logic       wdf,
    input logic [7:0] rd_data,
    input wd_state_e  wd_state
);
    // R9
    pwr_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_fail |=> (rd_data == 8'h00 && rst_out_n && wd_state == WD_IDLE));

    // R4
    pulse_clears_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_out_n) |-> (rd_data == 8'h00));

    // R4
    pulse_ends_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rst_out_n && !tick && !pwr_fail) |=> !rst_out_n);

    // R2
    flag_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wdf) |-> $past(tick));

    // R5
    flag_read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_rd && !tick) |=> !wdf);

    // R8
    zero_write_idles_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data == 8'h00 && wd_state != WD_RST_PULSE) |=> (wd_state == WD_IDLE));

    // R10
    irq_dominates_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_state == WD_IRQ_HOLD) |-> irq_ft);
endmodule

bind wdog_steer_top wdog_steer_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .flag_rd   (flag_rd),
    .pwr_fail  (pwr_fail),
    .irq_ft    (irq_ft),
    .rst_out_n (rst_out_n),
    .wdf       (wdf),
    .rd_data   (rd_data),
    .wd_state  (wd_state)
);

// File: tb/tb_wdog_steer_top.sv
module tb_wdog_steer_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       flag_rd = 1'b0;
    logic       kick = 1'b0;
    logic       pwr_fail = 1'b0;
    logic       ft_en = 1'b0;
    logic       ft_wave = 1'b0;
    logic       irq_ft;
    logic       rst_out_n;
    logic       wdf;
    logic       ft_clr;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    wdog_steer_top dut (
        .clk (clk), .rst_n (rst_n), .tick (tick), .wr_en (wr_en),
        .wr_data (wr_data), .rd_data (rd_data), .flag_rd (flag_rd),
        .kick (kick), .pwr_fail (pwr_fail), .ft_en (ft_en),
        .ft_wave (ft_wave), .irq_ft (irq_ft), .rst_out_n (rst_out_n),
        .wdf (wdf), .ft_clr (ft_clr)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic write_ctrl(input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_data = d;
        @(negedge clk); wr_en = 1'b0; wr_data = 8'h00;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic read_flags();
        @(negedge clk); flag_rd = 1'b1;
        @(negedge clk); flag_rd = 1'b0;
    endtask

    task automatic clear_all();
        write_ctrl(8'h00); read_flags(); idle(2);
    endtask

    task automatic t_reset();
        check(rd_data == 8'h00 && irq_ft == 1'b0 && rst_out_n && !wdf && !ft_clr,
              "R1 reset state", {rd_data, irq_ft, rst_out_n, wdf}, 8'h02);
    endtask

    task automatic t_readback();
        write_ctrl(8'hA5);
        check(rd_data == 8'hA5, "R1 readback", rd_data, 8'hA5);
        write_ctrl(8'h00);
        check(rd_data == 8'h00, "R1 readback zero", rd_data, 0);
    endtask

    task automatic t_timeout(input logic [4:0] m, input logic [1:0] code, input int total);
        write_ctrl({1'b0, m, code}); idle(3);
        ticks(total - 1);
        check(irq_ft == 1'b0 && !wdf, "R2 no early timeout", irq_ft, 0);
        ticks(1);
        check(irq_ft == 1'b1, "R2 R3 timeout irq", irq_ft, 1);
        check(wdf == 1'b1, "R3 flag set", wdf, 1);
        ticks(3);
        check(irq_ft == 1'b1 && rst_out_n, "R3 irq held", irq_ft, 1);
        clear_all();
        check(irq_ft == 1'b0 && !wdf, "R3 cleared by 00h", irq_ft, 0);
    endtask

    task automatic t_steer_reset();
        write_ctrl(8'h84); idle(3);
        ticks(1);
        check(!rst_out_n, "R4 pulse starts", rst_out_n, 0);
        check(rd_data == 8'h00, "R4 ctrl cleared", rd_data, 0);
        check(ft_clr == 1'b1 && wdf, "R4 ft_clr and flag", ft_clr, 1);
        check(irq_ft == 1'b0, "R4 no irq", irq_ft, 0);
        idle(1);
        check(ft_clr == 1'b0, "R4 ft_clr one cycle", ft_clr, 0);
        ticks(1);
        check(!rst_out_n, "R4 still low after one tick", rst_out_n, 0);
        ticks(1);
        check(rst_out_n, "R4 pulse ends after two ticks", rst_out_n, 1);
        ticks(4);
        check(rst_out_n && irq_ft == 1'b0, "R4 stays idle", rst_out_n, 1);
        read_flags();
        check(!wdf, "R5 flag cleared by read", wdf, 0);
    endtask

    task automatic t_flag_race();
        write_ctrl(8'h04); idle(3);
        @(negedge clk); tick = 1'b1; flag_rd = 1'b1;
        @(negedge clk); tick = 1'b0; flag_rd = 1'b0;
        check(wdf == 1'b1, "R5 set beats read", wdf, 1);
        read_flags();
        check(wdf == 1'b0, "R5 later read clears", wdf, 0);
        clear_all();
    endtask

    task automatic t_rewrite();
        write_ctrl(8'h10); idle(3);
        ticks(3);
        write_ctrl(8'h10); idle(2);
        ticks(3);
        check(irq_ft == 1'b0, "R6 rewrite restarts", irq_ft, 0);
        ticks(1);
        check(irq_ft == 1'b1, "R6 full length after rewrite", irq_ft, 1);
        clear_all();
    endtask

    task automatic t_kick();
        write_ctrl(8'h10); idle(3);
        ticks(3);
        @(negedge clk); kick = 1'b1; idle(5);
        ticks(3);
        check(irq_ft == 1'b0, "R7 rising kick restarts", irq_ft, 0);
        @(negedge clk); kick = 1'b0; idle(5);
        ticks(3);
        check(irq_ft == 1'b0, "R7 falling kick restarts", irq_ft, 0);
        ticks(1);
        check(irq_ft == 1'b1, "R7 timeout after last kick", irq_ft, 1);
        clear_all();
    endtask

    task automatic t_disable();
        write_ctrl(8'h08); idle(3);
        ticks(1);
        write_ctrl(8'h80); idle(2);
        ticks(6);
        check(irq_ft == 1'b0 && rst_out_n && !wdf, "R8 mult 0 disables", irq_ft, 0);
        write_ctrl(8'h04); idle(3);
        ticks(1);
        check(irq_ft == 1'b1, "R8 armed irq", irq_ft, 1);
        write_ctrl(8'h80); idle(2);
        check(irq_ft == 1'b1, "R8 non-zero write keeps irq", irq_ft, 1);
        write_ctrl(8'h00); idle(1);
        check(irq_ft == 1'b0, "R8 00h releases irq", irq_ft, 0);
        clear_all();
    endtask

    task automatic t_power();
        write_ctrl(8'h08); idle(3);
        @(negedge clk); pwr_fail = 1'b1;
        @(negedge clk); pwr_fail = 1'b0;
        check(rd_data == 8'h00, "R9 ctrl cleared", rd_data, 0);
        ticks(6);
        check(irq_ft == 1'b0 && !wdf, "R9 no timeout", irq_ft, 0);
        write_ctrl(8'h04); idle(3);
        ticks(1);
        @(negedge clk); pwr_fail = 1'b1;
        @(negedge clk); pwr_fail = 1'b0;
        check(irq_ft == 1'b0 && rst_out_n, "R9 irq released", irq_ft, 0);
        clear_all();
    endtask

    task automatic t_ft();
        @(negedge clk); ft_en = 1'b1; ft_wave = 1'b0; #1;
        check(irq_ft == 1'b0, "R10 ft low", irq_ft, 0);
        ft_wave = 1'b1; #1;
        check(irq_ft == 1'b1, "R10 ft high", irq_ft, 1);
        ft_wave = 1'b0;
        write_ctrl(8'h04); idle(3);
        ticks(1); #1;
        check(irq_ft == 1'b1, "R10 watchdog overrides ft", irq_ft, 1);
        clear_all();
        ft_en = 1'b0;
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        t_reset();
        t_readback();
        t_timeout(5'd5, 2'b00, 5);
        t_timeout(5'd2, 2'b01, 8);
        t_timeout(5'd3, 2'b10, 48);
        t_timeout(5'd1, 2'b11, 64);
        t_steer_reset();
        t_flag_race();
        t_rewrite();
        t_kick();
        t_disable();
        t_power();
        t_ft();
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 100000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule